// File: doc/BRIEF.md
# Frame Timing Marker Generator

This block turns a chip-rate enable into a set of periodic timing markers for a spread-spectrum baseband generator. It counts chips within a slot, slots within a radio frame, and frames within a wrapping frame number. Alongside these it keeps a separate chip count for the length of the stored chip sequence. Each counter boundary produces a marker: a slot clock, a radio frame clock, a sequence repetition marker and a frame number restart marker. The restart marker can be switched off.

With the default parameters a chip rate of 3.84 Mchip/s gives 2560 chips per slot, which is 0.667 ms. Fifteen slots make one 10 ms frame. The frame number is 12 bits wide and wraps after 4096 frames. A start pulse from the trigger controller puts every count back to its origin, so the next enabled chip is chip zero of a new sequence. Two selectors route any one of the four markers to each of the two marker output pins. All pins are plain control signals and carry no handshake.

Top module: `fmk_timing_gen`

## Requirements
- R1: While reset is asserted and after its release, both marker outputs are low and `frame_num` is 0.
- R2: Selector code 0 carries the slot marker. It is high for the one clock after an enabled chip whose index since the last start is a multiple of CHIPS_PER_SLOT, and low otherwise.
- R3: Selector code 1 carries the frame marker. It is high for the one clock after an enabled chip whose index is a multiple of CHIPS_PER_SLOT*SLOTS_PER_FRAME, and it never rises without the slot marker.
- R4: Selector code 2 carries the sequence marker. It is high after every enabled chip whose index is a multiple of SEQ_CHIPS, independent of slot and frame boundaries.
- R5: `frame_num` advances by one after the last chip of each frame and wraps from 2^FN_W-1 to 0. It holds its value otherwise.
- R6: Selector code 3 carries the restart marker. It is high after the first chip of a frame 0 that was reached by a wrap of `frame_num`, and only when `sfn_mark_en` was high at that chip. It stays low on the first chip after a start.
- R7: A `seq_start` cycle clears all counts and `frame_num`, even when `chip_en` is also high. No marker is raised for that cycle, and the next enabled chip is chip index 0.
- R8: After any clock cycle in which `chip_en` was low, all markers are low.
- R9: Each output follows its own selector (0 slot, 1 frame, 2 sequence, 3 restart). The two selectors may pick the same marker or different ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | One chip is processed in this cycle |
| seq_start | input | 1 | Restart pulse from the trigger controller |
| sfn_mark_en | input | 1 | Enables the frame number restart marker |
| sel_a | input | 2 | Marker selector for `mark_a` |
| sel_b | input | 2 | Marker selector for `mark_b` |
| mark_a | output | 1 | Selected marker, output A |
| mark_b | output | 1 | Selected marker, output B |
| frame_num | output | FN_W | Current frame number |

## Verification
The restart marker is the hardest case to reach, because it needs a full cycle of the frame number. The bench builds the block with short slots, short frames and a 3-bit frame number, so a wrap takes 96 chips, and it checks the marker across two wraps. A start issued in mid-run, on a cycle where the chip enable is also high, is used to show that the first frame 0 after a start does not raise the marker. A run with gaps in the chip enable shows that each marker stays one clock wide.

// File: rtl/fmk_pkg.sv
package fmk_pkg;
  localparam int NUM_MARKS = 4;

  typedef enum logic [1:0] {
    SEL_SLOT  = 2'd0,
    SEL_FRAME = 2'd1,
    SEL_SEQ   = 2'd2,
    SEL_SFN   = 2'd3
  } mark_sel_e;
endpackage

// File: rtl/fmk_mod_counter.sv
module fmk_mod_counter #(
  parameter int MOD = 4,
  localparam int W = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fmk_marker_mux.sv
module fmk_marker_mux
  import fmk_pkg::*;
(
  input  logic [NUM_MARKS-1:0] marks,
  input  logic [1:0]           sel,
  output logic                 mark_o
);
  always_comb begin
    unique case (mark_sel_e'(sel))
      SEL_SLOT:  mark_o = marks[SEL_SLOT];
      SEL_FRAME: mark_o = marks[SEL_FRAME];
      SEL_SEQ:   mark_o = marks[SEL_SEQ];
      SEL_SFN:   mark_o = marks[SEL_SFN];
      default:   mark_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fmk_timing_gen.sv
module fmk_timing_gen
  import fmk_pkg::*;
#(
  parameter int CHIPS_PER_SLOT  = 2560,
  parameter int SLOTS_PER_FRAME = 15,
  parameter int FN_W            = 12,
  parameter int SEQ_CHIPS       = 76800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_en,
  input  logic            seq_start,
  input  logic            sfn_mark_en,
  input  logic [1:0]      sel_a,
  input  logic [1:0]      sel_b,
  output logic            mark_a,
  output logic            mark_b,
  output logic [FN_W-1:0] frame_num
);
  localparam int CHIP_W = (CHIPS_PER_SLOT > 1) ? $clog2(CHIPS_PER_SLOT) : 1;
  localparam int SLOT_W = (SLOTS_PER_FRAME > 1) ? $clog2(SLOTS_PER_FRAME) : 1;
  localparam int SEQ_W  = (SEQ_CHIPS > 1) ? $clog2(SEQ_CHIPS) : 1;
  localparam int FN_MOD = 2 ** FN_W;

  localparam logic [CHIP_W-1:0] CHIP_LAST = CHIP_W'(CHIPS_PER_SLOT - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS_PER_FRAME - 1);
  localparam logic [FN_W-1:0]   FN_LAST   = FN_W'(FN_MOD - 1);

  logic [CHIP_W-1:0] chip_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic [SEQ_W-1:0]  seq_cnt;

  logic chip_inc, slot_inc, fn_inc;
  logic chip_first, slot_first, fn_first, seq_first;
  logic fn_wrap;
  logic wrapped;
  logic [NUM_MARKS-1:0] mark_vec;

  // A start cycle never counts as a chip.
  assign chip_inc   = chip_en & ~seq_start;
  assign chip_first = (chip_cnt == '0);
  assign slot_first = (slot_cnt == '0);
  assign fn_first   = (frame_num == '0);
  assign seq_first  = (seq_cnt == '0);
  assign slot_inc   = chip_inc & (chip_cnt == CHIP_LAST);
  assign fn_inc     = slot_inc & (slot_cnt == SLOT_LAST);
  assign fn_wrap    = fn_inc & (frame_num == FN_LAST);

  fmk_mod_counter #(.MOD(CHIPS_PER_SLOT)) u_chip_cnt (
    .clk(clk), .rst_n(rst_n), .clr(seq_start), .inc(chip_inc), .cnt(chip_cnt)
  );

  fmk_mod_counter #(.MOD(SLOTS_PER_FRAME)) u_slot_cnt (
    .clk(clk), .rst_n(rst_n), .clr(seq_start), .inc(slot_inc), .cnt(slot_cnt)
  );

  fmk_mod_counter #(.MOD(FN_MOD)) u_frame_cnt (
    .clk(clk), .rst_n(rst_n), .clr(seq_start), .inc(fn_inc), .cnt(frame_num)
  );

  fmk_mod_counter #(.MOD(SEQ_CHIPS)) u_seq_cnt (
    .clk(clk), .rst_n(rst_n), .clr(seq_start), .inc(chip_inc), .cnt(seq_cnt)
  );

  // Distinguishes a frame 0 reached by wrap from one reached by start.
  always_ff @(posedge clk) begin
    if (!rst_n || seq_start) begin
      wrapped <= 1'b0;
    end else if (fn_wrap) begin
      wrapped <= 1'b1;
    end
  end

  // One-clock marker pulses for the chip just processed.
  always_ff @(posedge clk) begin
    if (!rst_n || !chip_inc) begin
      mark_vec <= '0;
    end else begin
      mark_vec[SEL_SLOT]  <= chip_first;
      mark_vec[SEL_FRAME] <= chip_first & slot_first;
      mark_vec[SEL_SEQ]   <= seq_first;
      mark_vec[SEL_SFN]   <= chip_first & slot_first & fn_first & wrapped & sfn_mark_en;
    end
  end

  fmk_marker_mux u_mux_a (.marks(mark_vec), .sel(sel_a), .mark_o(mark_a));
  fmk_marker_mux u_mux_b (.marks(mark_vec), .sel(sel_b), .mark_o(mark_b));
endmodule

// File: rtl/fmk_timing_chk.sv
module fmk_timing_chk #(
  parameter int FN_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            chip_en,
  input logic            seq_start,
  input logic            sfn_mark_en,
  input logic [3:0]      mark_vec,
  input logic [FN_W-1:0] frame_num
);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (mark_vec == 4'b0000));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (frame_num == '0) && (mark_vec == 4'b0000));

  a_r5_fn_step: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_start |=> (frame_num == $past(frame_num)) ||
                   (frame_num == FN_W'($past(frame_num) + 1'b1)));

  a_r6_sfn_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !sfn_mark_en |=> !mark_vec[3]);

  a_r6_sfn_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mark_vec[3] |-> mark_vec[1]);

  a_r3_frame_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mark_vec[1] |-> mark_vec[0]);
endmodule

bind fmk_timing_gen fmk_timing_chk #(.FN_W(FN_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .chip_en(chip_en),
  .seq_start(seq_start),
  .sfn_mark_en(sfn_mark_en),
  .mark_vec(mark_vec),
  .frame_num(frame_num)
);

// File: tb/tb_fmk_timing_gen.sv
module tb_fmk_timing_gen;
  localparam int CPS   = 4;
  localparam int SPF   = 3;
  localparam int FNW   = 3;
  localparam int SEQ   = 10;
  localparam int FRAME = CPS * SPF;
  localparam int WRAP  = FRAME * (2 ** FNW);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           chip_en = 1'b0;
  logic           seq_start = 1'b0;
  logic           sfn_mark_en = 1'b0;
  logic [1:0]     sel_a = 2'd0;
  logic [1:0]     sel_b = 2'd1;
  logic           mark_a, mark_b;
  logic [FNW-1:0] frame_num;

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fmk_timing_gen #(
    .CHIPS_PER_SLOT(CPS), .SLOTS_PER_FRAME(SPF), .FN_W(FNW), .SEQ_CHIPS(SEQ)
  ) dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .seq_start(seq_start),
    .sfn_mark_en(sfn_mark_en), .sel_a(sel_a), .sel_b(sel_b),
    .mark_a(mark_a), .mark_b(mark_b), .frame_num(frame_num)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (chip %0d)", req, got, exp, k);
    end
  endtask

  function automatic string code_req(input int code);
    case (code)
      0: return "R2 R9";
      1: return "R3 R9";
      2: return "R4 R9";
      default: return "R6 R9";
    endcase
  endfunction

  function automatic int exp_mark(input int code, input int idx, input bit sfn);
    case (code)
      0: return int'(idx % CPS == 0);
      1: return int'(idx % FRAME == 0);
      2: return int'(idx % SEQ == 0);
      default: return int'(sfn && idx > 0 && idx % WRAP == 0);
    endcase
  endfunction

  task automatic step(input logic en, input logic st);
    @(negedge clk);
    chip_en = en;
    seq_start = st;
    @(posedge clk);
    #1;
  endtask

  task automatic restart();
    step(1'b1, 1'b1);
    k = 0;
    chk("R7 mark_a", int'(mark_a), 0);
    chk("R7 mark_b", int'(mark_b), 0);
    chk("R7 frame_num", int'(frame_num), 0);
  endtask

  task automatic run_chips(input int sa, input int sb, input int n, input int gap, input bit sfn);
    @(negedge clk);
    sel_a = 2'(sa);
    sel_b = 2'(sb);
    sfn_mark_en = sfn;
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0);
      chk(code_req(sa), int'(mark_a), exp_mark(sa, k, sfn));
      chk(code_req(sb), int'(mark_b), exp_mark(sb, k, sfn));
      k++;
      chk("R5 frame_num", int'(frame_num), (k / FRAME) % (2 ** FNW));
      for (int g = 0; g < gap; g++) begin
        step(1'b0, 1'b0);
        chk("R8 mark_a idle", int'(mark_a), 0);
        chk("R8 mark_b idle", int'(mark_b), 0);
        chk("R5 frame_num hold", int'(frame_num), (k / FRAME) % (2 ** FNW));
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mark_a in reset", int'(mark_a), 0);
    chk("R1 frame_num in reset", int'(frame_num), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    chk("R1 mark_a", int'(mark_a), 0);
    chk("R1 mark_b", int'(mark_b), 0);
    chk("R1 frame_num", int'(frame_num), 0);
  endtask

  task automatic t_slot_frame();
    restart();
    run_chips(0, 1, 2 * WRAP + 5, 0, 1'b1);
  endtask

  task automatic t_seq_sfn();
    restart();
    run_chips(2, 3, 2 * WRAP + 5, 0, 1'b1);
  endtask

  task automatic t_sfn_disabled();
    restart();
    run_chips(3, 3, WRAP + 10, 0, 1'b0);
  endtask

  task automatic t_gapped();
    restart();
    run_chips(0, 2, 40, 2, 1'b1);
  endtask

  task automatic t_midrun_restart();
    restart();
    run_chips(1, 3, 50, 0, 1'b1);
    restart();
    run_chips(1, 3, WRAP + 14, 0, 1'b1);
  endtask

  task automatic t_swap_selectors();
    restart();
    run_chips(3, 0, WRAP + 2, 1, 1'b1);
    run_chips(2, 1, 30, 0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_slot_frame();
    t_seq_sfn();
    t_sfn_disabled();
    t_gapped();
    t_midrun_restart();
    t_swap_selectors();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule